// File: doc/BRIEF.md
# Banked Change-of-State Input Port

This block is a 48-line, input-only digital port with a byte-wide register interface that occupies an eight-address I/O window. Internally the lines are split into six byte-wide groups. A host read of a group's address returns that group's current level, taken after a two-flop synchroniser. The addresses are not contiguous: offset 3 is an unused hole, and offset 7 is a combined control and status register.

Writing offset 7 arms change-of-state detection for any subset of the six groups. A rising or falling transition on any line of an armed group latches a flag for that group. The shared interrupt request stays high while any flag is latched. A read of offset 7 reports the latched flags together with an active-low pending bit, and the same read acknowledges them. A change that lands in the cycle of that acknowledging read is kept for the next read.

Top module: `cos_input_port`

## Requirements
- R1: Reset is synchronous and active-high. After reset, `irq` is 0, the arm mask is 0, and a status read (offset 7) returns 0x40.
- R2: A read of offset 0, 1, 2, 4, 5 or 6 returns group 0, 1, 2, 3, 4 or 5 in that order. Bit n of group g is line g*8+n.
- R3: A read of offset 3 returns 0x00. Bit 7 of the status byte always reads 0.
- R4: A write to offset 7 loads `bus_wdata[5:0]` as the arm mask, where bit k arms group k. Writes to any other offset change nothing.
- R5: A rising or falling transition on any line of an armed group k sets status bit k and raises `irq`. Both appear at the third rising clock edge after the input changes.
- R6: A transition on a line of an unarmed group sets no flag and does not raise `irq`.
- R7: Status bit 6 is the inverse of `irq`, so 0 means an interrupt is pending.
- R8: A status read clears every latched flag and drops `irq` at the clock edge that ends the read, unless R9 applies.
- R9: A change on an armed group that is detected in the same cycle as the acknowledging status read is latched. It appears in the next status read.
- R10: A live group read reflects an input change after exactly two rising clock edges (two-flop synchroniser).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| in_lines | input | 48 | Asynchronous input lines |
| bus_addr | input | 3 | Register offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; a status read acknowledges at the edge it is sampled |
| bus_rdata | output | 8 | Read data, valid combinationally while `bus_rd` is high, else 0 |
| irq | output | 1 | Shared change-of-state interrupt request, active high |

## Verification
The checker watches these rules on every cycle:
- the hole and bit 7 always read as zero;
- status bit 6 mirrors the inverse of the interrupt line;
- flags hold steady when there is no armed change and no acknowledge;
- an armed change always leaves the interrupt raised one cycle later;
- an acknowledge with no competing change leaves all flags clear.

Only the bench scenarios show the remaining behaviour:
- the gapped mapping of offsets to groups and bit positions;
- the exact synchroniser and flag latency;
- that writes to other offsets leave the arm mask untouched;
- the race between a change and the acknowledging read;
- which specific groups are flagged for random arm masks and input patterns.

// File: rtl/cos_port_pkg.sv
package cos_port_pkg;

    localparam int GROUP_W    = 8;
    localparam int NUM_GROUPS = 6;
    localparam int LINES      = GROUP_W * NUM_GROUPS;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int SYNC_DEPTH = 2;
    localparam int GSEL_W     = $clog2(NUM_GROUPS);

    localparam logic [ADDR_W-1:0] STATUS_OFS = 3'd7;
    localparam logic [ADDR_W-1:0] HOLE_OFS   = 3'd3;

    typedef logic [NUM_GROUPS-1:0] grp_vec_t;

    // Status byte layout: bit 7 reserved zero, bit 6 pending (active low), bits 5:0 group flags
    typedef struct packed {
        logic     rsvd;
        logic     pend_n;
        grp_vec_t flags;
    } status_t;

    typedef enum logic [1:0] {
        SEL_GROUP  = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_HOLE   = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e         kind;
        logic [GSEL_W-1:0] grp;
    } rd_sel_t;

    // Offsets below the hole map directly, offsets above it are shifted down by one
    function automatic rd_sel_t decode_offset(logic [ADDR_W-1:0] ofs);
        rd_sel_t s;
        s.kind = SEL_GROUP;
        s.grp  = '0;
        if (ofs == STATUS_OFS) begin
            s.kind = SEL_STATUS;
        end else if (ofs == HOLE_OFS) begin
            s.kind = SEL_HOLE;
        end else if (ofs < HOLE_OFS) begin
            s.grp = GSEL_W'(ofs);
        end else begin
            s.grp = GSEL_W'(ofs - 3'd1);
        end
        return s;
    endfunction

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int W     = 48,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < DEPTH; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_out = stage_q[DEPTH-1];

endmodule

// File: rtl/cos_change_det.sv
module cos_change_det
    import cos_port_pkg::*;
#(
    parameter int GW = GROUP_W,
    parameter int NG = NUM_GROUPS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [GW*NG-1:0] level,
    output logic [NG-1:0]   grp_chg
);

    logic [GW*NG-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= level;
        end
    end

    // Any toggle in either direction inside a group marks that group
    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_chg[g] = |(level[g*GW +: GW] ^ prev_q[g*GW +: GW]);
    end

endmodule

// File: rtl/cos_status_ctrl.sv
module cos_status_ctrl
    import cos_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     arm_we,
    input  grp_vec_t arm_wdata,
    input  logic     ack,
    input  grp_vec_t grp_chg,
    output grp_vec_t arm_mask,
    output grp_vec_t grp_flags,
    output logic     irq
);

    grp_vec_t armed_chg;
    grp_vec_t flags_d;

    assign armed_chg = grp_chg & arm_mask;

    always_comb begin
        flags_d = ack ? '0 : grp_flags;
        flags_d = flags_d | armed_chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_mask  <= '0;
            grp_flags <= '0;
        end else begin
            if (arm_we) begin
                arm_mask <= arm_wdata;
            end
            grp_flags <= flags_d;
        end
    end

    assign irq = |grp_flags;

endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
    import cos_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [LINES-1:0]   in_lines,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq
);

    logic [LINES-1:0] sync_lines;
    grp_vec_t         grp_chg;
    grp_vec_t         arm_mask;
    grp_vec_t         grp_flags;
    rd_sel_t          rsel;
    status_t          stat;
    logic             status_ack;
    logic             arm_we;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_GROUPS];

    cos_sync #(.W(LINES), .DEPTH(SYNC_DEPTH)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (in_lines),
        .sync_out (sync_lines)
    );

    cos_change_det #(.GW(GROUP_W), .NG(NUM_GROUPS)) det_i (
        .clk     (clk),
        .rst     (rst),
        .level   (sync_lines),
        .grp_chg (grp_chg)
    );

    assign arm_we     = bus_wr && (bus_addr == STATUS_OFS);
    assign status_ack = bus_rd && (bus_addr == STATUS_OFS);

    cos_status_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .arm_we    (arm_we),
        .arm_wdata (bus_wdata[NUM_GROUPS-1:0]),
        .ack       (status_ack),
        .grp_chg   (grp_chg),
        .arm_mask  (arm_mask),
        .grp_flags (grp_flags),
        .irq       (irq)
    );

    always_comb begin
        stat.rsvd   = 1'b0;
        stat.pend_n = ~irq;
        stat.flags  = grp_flags;
    end

    assign rsel = decode_offset(bus_addr);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (rsel.kind)
                SEL_GROUP:  bus_rdata = sync_lines[int'(rsel.grp)*GROUP_W +: GROUP_W];
                SEL_STATUS: bus_rdata = stat;
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cos_port_chk.sv
module cos_port_chk
    import cos_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input grp_vec_t          grp_chg,
    input grp_vec_t          arm_mask,
    input grp_vec_t          grp_flags
);

    logic stat_rd;
    logic armed_hit;

    assign stat_rd   = bus_rd && (bus_addr == STATUS_OFS);
    assign armed_hit = |(grp_chg & arm_mask);

    // R3: hole offset reads zero
    a_r3_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == HOLE_OFS) |-> (bus_rdata == 8'h00));

    // R3: status bit 7 reads zero
    a_r3_bit7_zero: assert property (@(posedge clk) disable iff (rst)
        stat_rd |-> !bus_rdata[7]);

    // R7: pending bit is the inverse of the request line
    a_r7_pend_inverse: assert property (@(posedge clk) disable iff (rst)
        stat_rd |-> (bus_rdata[6] == !irq));

    // R5: an armed change always yields a raised request next cycle
    a_r5_armed_raises: assert property (@(posedge clk) disable iff (rst)
        armed_hit |=> irq);

    // R6: without an armed change or acknowledge, flags hold
    a_r6_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (!armed_hit && !stat_rd) |=> $stable(grp_flags));

    // R8: an acknowledge with no competing change clears all flags
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !armed_hit) |=> (grp_flags == '0 && !irq));

endmodule

bind cos_input_port cos_port_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .grp_chg   (grp_chg),
    .arm_mask  (arm_mask),
    .grp_flags (grp_flags)
);

// File: tb/cos_input_port_tb_top.sv
module cos_input_port_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [47:0] in_lines;
    logic [2:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic        bus_rd;
    logic [7:0]  bus_rdata;
    logic        irq;

    int n_cmp  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cos_input_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_lines  (in_lines),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] ofs_of_group(int g);
        return (g < 3) ? 3'(g) : 3'(g + 1);
    endfunction

    function automatic logic [5:0] exp_flags(logic [47:0] a, logic [47:0] b, logic [5:0] arm);
        logic [5:0] f = '0;
        for (int g = 0; g < 6; g++) begin
            f[g] = arm[g] && (a[g*8 +: 8] != b[g*8 +: 8]);
        end
        return f;
    endfunction

    function automatic logic [7:0] exp_status(logic [5:0] f);
        return {1'b0, ~(|f), f};
    endfunction

    task automatic bus_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    // Combinational look without crossing a clock edge (group and hole offsets only)
    task automatic peek(logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [47:0] old_v;
        logic [47:0] new_v;
        logic [5:0]  arm;
        logic [5:0]  ef;
        void'($urandom(32'h5EED_0C05));

        rst = 1'b1; in_lines = 48'h0; bus_addr = '0; bus_wr = 0; bus_wdata = '0; bus_rd = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        bus_read(3'd7, d);
        check("R1 status after reset", d, 8'h40);

        // R2: group mapping and bit order
        in_lines = 48'h665544_332211;
        settle();
        for (int g = 0; g < 6; g++) begin
            peek(ofs_of_group(g), d);
            check($sformatf("R2 group %0d", g), d, in_lines[g*8 +: 8]);
        end
        in_lines = 48'h1 << 43;  // line 43 = group 5 bit 3
        settle();
        peek(3'd6, d);
        check("R2 line 43 bit position", d, 8'h08);

        // R3: hole reads zero
        peek(3'd3, d);
        check("R3 hole", d, 8'h00);

        // R10: two-flop latency on live reads
        @(negedge clk);
        in_lines = 48'h0000_0000_00A5;
        @(negedge clk);
        peek(3'd0, d);
        check("R10 one edge still old", d, 8'h00);
        @(negedge clk);
        peek(3'd0, d);
        check("R10 two edges new", d, 8'hA5);
        settle();

        // R4: writes to other offsets ignored
        bus_write(3'd0, 8'h3F);
        bus_write(3'd3, 8'h3F);
        bus_write(3'd5, 8'h3F);
        in_lines = ~in_lines;
        settle();
        check("R4 non-status writes ignored irq", {7'd0, irq}, 8'h00);
        bus_read(3'd7, d);
        check("R4 non-status writes ignored status", d, 8'h40);

        // R5: falling edge on armed group 2, exact latency
        bus_write(3'd7, 8'hC4);  // bits 7:6 ignored, arms group 2
        @(negedge clk);
        in_lines[16] = ~in_lines[16];
        repeat (2) @(negedge clk);
        check("R5 not yet after two edges", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R5 irq at third edge", {7'd0, irq}, 8'h01);
        bus_read(3'd7, d);
        check("R5 R7 status group 2", d, 8'h04);
        check("R8 irq cleared by read", {7'd0, irq}, 8'h00);
        bus_read(3'd7, d);
        check("R8 status after clear", d, 8'h40);

        // R6: change on unarmed group only
        in_lines[7:0] = ~in_lines[7:0];
        settle();
        check("R6 unarmed irq", {7'd0, irq}, 8'h00);

        // R9: change detected in the acknowledge cycle is retained
        bus_write(3'd7, 8'h01);
        @(negedge clk);
        in_lines[0] = ~in_lines[0];
        repeat (2) @(negedge clk);
        bus_addr = 3'd7;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        check("R9 read before latch", d, 8'h40);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R9 irq kept", {7'd0, irq}, 8'h01);
        bus_read(3'd7, d);
        check("R9 flag in next read", d, 8'h01);

        // Random: R5 R6 R7 R8 with both edge directions
        for (int it = 0; it < 200; it++) begin
            arm = 6'($urandom);
            bus_write(3'd7, {2'($urandom), arm});
            bus_read(3'd7, d);
            old_v = in_lines;
            new_v = old_v;
            for (int g = 0; g < 6; g++) begin
                if ($urandom_range(0, 1) == 1) begin
                    new_v[g*8 + $urandom_range(0, 7)] ^= 1'b1;
                end
            end
            @(negedge clk);
            in_lines = new_v;
            settle();
            ef = exp_flags(old_v, new_v, arm);
            check("R5 R6 random irq", {7'd0, irq}, {7'd0, |ef});
            bus_read(3'd7, d);
            check("R5 R7 random status", d, exp_status(ef));
            check("R8 random cleared", {7'd0, irq}, 8'h00);
            peek(ofs_of_group(it % 6), d);
            check("R2 random live", d, new_v[(it % 6)*8 +: 8]);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule